// File: doc/BRIEF.md
# Segmented Hyperbolic Tangent Approximator

This block approximates tanh(x) for a signed fixed-point input by splitting a chosen input interval into evenly spaced segments. Each segment outputs one constant: the tanh of the segment's lower edge. The segment count and the interval end points are elaboration-time parameters. All edge and output constants are worked out during elaboration and quantized into the fixed-point format. The netlist therefore holds only comparators against constant edges and a constant multiplexer, with no transcendental arithmetic.

The input is compared directly against the quantized edge constants, so no input-to-address translation is needed. A single constant table is indexed by the comparison result. Inputs outside the covered interval clamp to the first or last entry. A parameter inserts one output register stage for timing closure.

Top module: `tanh_seg_lut`

## Requirements
- R1: Input and output are signed two's complement fixed-point words of INT_W+FRAC_W bits (default 8+8), with value = code / 2^FRAC_W.
- R2: For N_SEG segments, edge k (k = 0..N_SEG) is RNG_LO + (RNG_HI - RNG_LO)*k/N_SEG, rounded to the nearest input code.
- R3: Segment k is chosen when edge k < x <= edge k+1, so a segment includes its upper edge and excludes its lower edge.
- R4: The output of segment k is tanh(edge k), taken on the unquantized edge and rounded to the nearest output code, with ties away from zero.
- R5: An input at or below edge 0 gives the output of segment 0.
- R6: An input above edge N_SEG gives the output of segment N_SEG-1.
- R7: With PIPE_EN = 0 the output follows the input combinationally, in the same cycle.
- R8: With PIPE_EN = 1 the output is registered and shows the result for the input sampled at the previous rising clock edge. A synchronous active-low reset clears the output to code 0.
- R9: For every input exactly one segment is selected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Synchronous active-low reset |
| x_i | input | INT_W+FRAC_W | Signed fixed-point argument |
| y_o | output | INT_W+FRAC_W | Signed fixed-point approximation of tanh |

## Verification
The bench builds two instances. The first is combinational, with four segments over 0.0 to 4.0. Its unit-wide segments put the edges at exact codes 0, 256, 512, 768 and 1024, so the tests can probe one code either side of each edge and the most positive and most negative words. The second is registered, with five segments over -2.5 to 2.5. This brings negative edges and negative output constants within reach, along with their rounding direction, the one-cycle latency and the reset value.

// File: rtl/tanh_lut_pkg.sv
// Package: elaboration-time helpers for the segmented tanh approximator.
// All functions use real arithmetic and are evaluated only while parameters
// are resolved; none of them produces hardware.
package tanh_lut_pkg;

    // Scale factor 2^frac as a real number.
    function automatic real pow2r(input int frac);
        real s;
        s = 1.0;
        for (int k = 0; k < frac; k++) s = s * 2.0;
        return s;
    endfunction

    // Real value to nearest w-bit code (ties away from zero), saturated.
    function automatic longint to_code(input real v, input int frac, input int w);
        real    t;
        longint r;
        longint hi;
        longint lo;
        t  = v * pow2r(frac);
        r  = (t >= 0.0) ? longint'($rtoi(t + 0.5)) : -longint'($rtoi(0.5 - t));
        hi = (longint'(1) <<< (w - 1)) - 1;
        lo = -(longint'(1) <<< (w - 1));
        if (r > hi) r = hi;
        if (r < lo) r = lo;
        return r;
    endfunction

    // Hyperbolic tangent from the exponential.
    function automatic real tanh_r(input real v);
        real e;
        if (v > 40.0)  return 1.0;
        if (v < -40.0) return -1.0;
        e = $exp(2.0 * v);
        return (e - 1.0) / (e + 1.0);
    endfunction

    // Real position of edge k out of n evenly spaced segments.
    function automatic real edge_r(input real lo, input real hi, input int n, input int k);
        return lo + (hi - lo) * real'(k) / real'(n);
    endfunction

    // Quantized edge k.
    function automatic longint edge_code(input real lo, input real hi, input int n,
                                         input int k, input int frac, input int w);
        return to_code(edge_r(lo, hi, n, k), frac, w);
    endfunction

    // Quantized output constant of segment k: tanh of its unquantized lower edge.
    function automatic longint seg_code(input real lo, input real hi, input int n,
                                        input int k, input int frac, input int w);
        return to_code(tanh_r(edge_r(lo, hi, n, k)), frac, w);
    endfunction

endpackage

// File: rtl/tanh_edge_cmp.sv
// Edge comparator bank. Compares the input against the interior edges
// 1..N_SEG-1 and produces a thermometer code: above_o[k] = (x > edge k).
// Bit 0 is tied high, because any input at or below edge 0 clamps to
// segment 0. Assumes the edges rise with k (RNG_HI > RNG_LO).
module tanh_edge_cmp
    import tanh_lut_pkg::*;
#(
    parameter int  W      = 16,
    parameter int  FRAC_W = 8,
    parameter int  N_SEG  = 16,
    parameter real RNG_LO = 0.0,
    parameter real RNG_HI = 5.0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic signed [W-1:0] x_i,
    output logic [N_SEG-1:0]    above_o
);

    // Lowest segment is always reachable (clamp from below).
    assign above_o[0] = 1'b1;

    for (genvar k = 1; k < N_SEG; k++) begin : g_edge
        localparam logic signed [W-1:0] EDGE_Q = W'(edge_code(RNG_LO, RNG_HI, N_SEG, k, FRAC_W, W));
        // Strict compare: an input equal to the edge stays in the lower segment.
        assign above_o[k] = (x_i > EDGE_Q);
    end

    // Thermometer ordering: passing a higher edge implies passing every lower one.
    for (genvar k = 1; k + 1 < N_SEG; k++) begin : g_chk
        // R3
        therm_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
            above_o[k+1] |-> above_o[k]);
    end

endmodule

// File: rtl/tanh_seg_select.sv
// Segment decoder. Turns the thermometer code from the comparator bank into
// a one-hot segment select. The top segment is chosen whenever its lower edge
// is passed, which also covers the clamp for inputs above the last edge.
module tanh_seg_select #(
    parameter int N_SEG = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SEG-1:0] above_i,
    output logic [N_SEG-1:0] sel_o
);

    for (genvar k = 0; k < N_SEG; k++) begin : g_sel
        if (k == N_SEG - 1) begin : g_top
            // Top segment: no upper edge to test.
            assign sel_o[k] = above_i[k];
        end else begin : g_mid
            // Inside segment k: past edge k but not past edge k+1.
            assign sel_o[k] = above_i[k] & ~above_i[k+1];
        end
    end

    // R9
    sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(sel_o) == 1);

endmodule

// File: rtl/tanh_seg_rom.sv
// Constant table. Holds the quantized tanh constant of each segment and
// returns the one picked by the one-hot select with an AND-OR tree.
// Assumes sel_i is one-hot.
module tanh_seg_rom
    import tanh_lut_pkg::*;
#(
    parameter int  W      = 16,
    parameter int  FRAC_W = 8,
    parameter int  N_SEG  = 16,
    parameter real RNG_LO = 0.0,
    parameter real RNG_HI = 5.0
) (
    input  logic [N_SEG-1:0]    sel_i,
    output logic signed [W-1:0] y_o
);

    logic [W-1:0] term [N_SEG];

    for (genvar k = 0; k < N_SEG; k++) begin : g_val
        localparam logic [W-1:0] VAL_Q = W'(seg_code(RNG_LO, RNG_HI, N_SEG, k, FRAC_W, W));
        // Gate the constant of segment k with its select bit.
        assign term[k] = sel_i[k] ? VAL_Q : '0;
    end

    // OR-reduce the gated constants into the output word.
    always_comb begin
        logic [W-1:0] acc;
        acc = '0;
        for (int k = 0; k < N_SEG; k++) acc = acc | term[k];
        y_o = signed'(acc);
    end

endmodule

// File: rtl/tanh_out_stage.sv
// Output stage. With PIPE_EN = 0 it is a wire; with PIPE_EN = 1 it is one
// register with synchronous active-low reset to zero.
module tanh_out_stage #(
    parameter int W       = 16,
    parameter bit PIPE_EN = 1'b0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic signed [W-1:0] d_i,
    output logic signed [W-1:0] q_o
);

    if (PIPE_EN) begin : g_reg
        // Register the looked-up value; reset clears it.
        always_ff @(posedge clk) begin
            if (!rst_n) q_o <= '0;
            else        q_o <= d_i;
        end

        // R8
        reg_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) |-> q_o == $past(d_i));
    end else begin : g_wire
        // Pass straight through.
        assign q_o = d_i;
    end

endmodule

// File: rtl/tanh_seg_lut.sv
// Top: piecewise-constant tanh approximation over N_SEG evenly spaced
// segments of [RNG_LO, RNG_HI]. The input is compared with elaboration-time
// edge constants, the matching segment's constant is selected and optionally
// registered. Assumes RNG_HI > RNG_LO, N_SEG >= 1 and INT_W >= 2, so that
// +/-1.0 fits the output format.
module tanh_seg_lut
    import tanh_lut_pkg::*;
#(
    parameter int  INT_W   = 8,
    parameter int  FRAC_W  = 8,
    parameter int  N_SEG   = 16,
    parameter real RNG_LO  = 0.0,
    parameter real RNG_HI  = 5.0,
    parameter bit  PIPE_EN = 1'b0
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic signed [INT_W+FRAC_W-1:0] x_i,
    output logic signed [INT_W+FRAC_W-1:0] y_o
);

    localparam int W = INT_W + FRAC_W;
    localparam logic signed [W-1:0] EDGE_LO_Q = W'(edge_code(RNG_LO, RNG_HI, N_SEG, 0, FRAC_W, W));
    localparam logic signed [W-1:0] EDGE_HI_Q = W'(edge_code(RNG_LO, RNG_HI, N_SEG, N_SEG, FRAC_W, W));
    localparam logic signed [W-1:0] VAL_FIRST = W'(seg_code(RNG_LO, RNG_HI, N_SEG, 0, FRAC_W, W));
    localparam logic signed [W-1:0] VAL_LAST  = W'(seg_code(RNG_LO, RNG_HI, N_SEG, N_SEG - 1, FRAC_W, W));

    logic [N_SEG-1:0]    above;
    logic [N_SEG-1:0]    sel;
    logic signed [W-1:0] y_comb;

    tanh_edge_cmp #(
        .W(W), .FRAC_W(FRAC_W), .N_SEG(N_SEG), .RNG_LO(RNG_LO), .RNG_HI(RNG_HI)
    ) i_cmp (
        .clk(clk), .rst_n(rst_n), .x_i(x_i), .above_o(above)
    );

    tanh_seg_select #(
        .N_SEG(N_SEG)
    ) i_sel (
        .clk(clk), .rst_n(rst_n), .above_i(above), .sel_o(sel)
    );

    tanh_seg_rom #(
        .W(W), .FRAC_W(FRAC_W), .N_SEG(N_SEG), .RNG_LO(RNG_LO), .RNG_HI(RNG_HI)
    ) i_rom (
        .sel_i(sel), .y_o(y_comb)
    );

    tanh_out_stage #(
        .W(W), .PIPE_EN(PIPE_EN)
    ) i_out (
        .clk(clk), .rst_n(rst_n), .d_i(y_comb), .q_o(y_o)
    );

    // R5
    clamp_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (x_i <= EDGE_LO_Q) |-> (y_comb == VAL_FIRST));

    // R6
    clamp_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (x_i > EDGE_HI_Q) |-> (y_comb == VAL_LAST));

endmodule

// File: tb/test_tanh_seg_lut.sv
// Directed bench: a combinational instance (4 segments over 0..4) and a
// registered instance (5 segments over -2.5..2.5).
module test_tanh_seg_lut;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic signed [15:0] xa = '0;
    logic signed [15:0] ya;
    logic signed [15:0] xb = '0;
    logic signed [15:0] yb;
    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    tanh_seg_lut #(
        .INT_W(8), .FRAC_W(8), .N_SEG(4), .RNG_LO(0.0), .RNG_HI(4.0), .PIPE_EN(1'b0)
    ) i_tanh_seg_lut (
        .clk(clk), .rst_n(rst_n), .x_i(xa), .y_o(ya)
    );

    tanh_seg_lut #(
        .INT_W(8), .FRAC_W(8), .N_SEG(5), .RNG_LO(-2.5), .RNG_HI(2.5), .PIPE_EN(1'b1)
    ) i_tanh_seg_lut_p (
        .clk(clk), .rst_n(rst_n), .x_i(xb), .y_o(yb)
    );

    task automatic report(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Combinational instance: drive, settle, compare in the same cycle (R7).
    task automatic comb_probe(input int x, input int exp, input string req);
        @(negedge clk);
        xa = 16'(x);
        #1;
        report(req, int'(ya), exp);
    endtask

    // Registered instance: drive at negedge, captured at posedge, read next negedge.
    task automatic pipe_probe(input int x, input int exp, input string req);
        @(negedge clk);
        xb = 16'(x);
        #1;
        @(negedge clk);
        report(req, int'(yb), exp);
    endtask

    // Reset state of the registered output (R8).
    task automatic test_reset;
        @(negedge clk);
        xb = 16'sd500;
        @(negedge clk);
        report("R8 reset value", int'(yb), 0);
    endtask

    // Segment interiors and edge inclusion; edges at codes 0,256,512,768,1024,
    // constants 0,195,247,255 (R1, R2, R3, R4, R7).
    task automatic test_segments;
        comb_probe(1,    0,   "R3 seg0 just above edge0");
        comb_probe(256,  0,   "R3 edge1 belongs to seg0");
        comb_probe(257,  195, "R4 seg1 value tanh(1)");
        comb_probe(512,  195, "R3 edge2 belongs to seg1");
        comb_probe(513,  247, "R4 seg2 value tanh(2)");
        comb_probe(700,  247, "R2 seg2 interior");
        comb_probe(768,  247, "R3 edge3 belongs to seg2");
        comb_probe(769,  255, "R4 seg3 value tanh(3)");
        comb_probe(1024, 255, "R1 top edge in last seg");
    endtask

    // Clamping at both ends (R5, R6).
    task automatic test_clamp;
        comb_probe(0,      0,   "R5 at edge0");
        comb_probe(-5,     0,   "R5 below edge0");
        comb_probe(-32768, 0,   "R5 most negative");
        comb_probe(1025,   255, "R6 above top edge");
        comb_probe(32767,  255, "R6 most positive");
    endtask

    // Registered instance: edges -640,-384,-128,128,384,640;
    // constants -253,-232,-118,118,232 (R4 negatives, R8 latency, R9).
    task automatic test_pipe;
        pipe_probe(-1000, -253, "R5 pipe clamp low");
        pipe_probe(-384,  -253, "R3 pipe edge1 in seg0");
        pipe_probe(-383,  -232, "R4 pipe tanh(-1.5)");
        pipe_probe(0,     -118, "R9 pipe seg2 tanh(-0.5)");
        pipe_probe(129,   118,  "R4 pipe tanh(0.5)");
        pipe_probe(641,   232,  "R6 pipe clamp high");
        // Latency: the output must still hold the old result before the edge.
        @(negedge clk);
        xb = -16'sd1000;
        #1;
        report("R8 output held until clock", int'(yb), 232);
        @(negedge clk);
        report("R8 output after one clock", int'(yb), -253);
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        repeat (2) @(negedge clk);
        test_reset();
        @(negedge clk);
        rst_n = 1'b1;
        test_segments();
        test_clamp();
        test_pipe();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule